// File: doc/BRIEF.md
# SIMD Instruction Fault Classifier

This block decides which architectural fault, if any, a packed floating-point vector instruction must raise. The decode and memory stages supply a snapshot of the relevant machine state on each check request. That snapshot holds the control-register enables, the presence of the required instruction extension, a lock-prefix flag, the processor mode, the properties of the memory operand, a pending page-fault request and an unmasked numeric-exception flag. The block returns one encoded fault with a valid strobe.

All conditions are evaluated in parallel. A fixed-priority encoder then picks the winner. The order from highest to lowest is: enable/extension/lock faults, device-not-available, segment or canonical address faults, operand alignment, page fault, and finally the fault derived from a numeric exception. The numeric exception is routed to one of two fault kinds by a single OS-enable bit.

Top module: `simd_fault_classifier`

## Requirements
- R1: When the emulation control bit is 1, the OS vector-state enable is 0, the extension-present flag is 0, or the lock prefix is set, the code is UD (1). This rule outranks every other rule.
- R2: When R1 does not apply and the task-switched bit is 1, the code is NM (2).
- R3: In protected (2), compatibility (3) and 64-bit (4) modes, and in the unused mode codes 5 to 7, which are handled like protected mode: a memory operand with `addr_ok` low gives SS (4) if `stack_seg` is 1, and GP (3) otherwise. `addr_ok` has no effect in real (0) and virtual-8086 (1) modes.
- R4: In real (0) and virtual-8086 (1) modes, a memory operand whose last byte (address + 15) lies above 0xFFFF gives GP (3).
- R5: A memory operand whose address bits [3:0] are not all zero gives GP (3) in every mode. This rule ranks below R1 to R4.
- R6: A page-fault request with a memory operand gives PF (5) in every mode except real mode, where it is ignored. This rule ranks below R5.
- R7: An unmasked numeric exception with no higher-ranked fault gives XM (6) when the OS SIMD-exception enable is 1, and UD (1) when it is 0.
- R8: `fault_vld` is high exactly in the cycle after a cycle with `chk_req` high. While it is high, `fault_code` carries the result, or NONE (0) when no rule applies. While `fault_vld` is low, `fault_code` is 0.
- R9: After reset, `fault_vld` is 0 and `fault_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_req | input | 1 | Check request; the inputs below are sampled with it |
| ctl_emul | input | 1 | Emulation control bit |
| ctl_tswitch | input | 1 | Task-switched control bit |
| ctl_vecstate_os | input | 1 | OS support for vector state save/restore |
| ctl_simdx_os | input | 1 | OS support for SIMD numeric-exception delivery |
| feat_ok | input | 1 | Required instruction extension is present |
| lock_pfx | input | 1 | Lock prefix present |
| cpu_mode | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| mem_op | input | 1 | Source operand is in memory |
| eff_addr | input | ADDR_W | Effective address of the memory operand |
| addr_ok | input | 1 | Address is legal: canonical in 64-bit mode, within segment otherwise |
| stack_seg | input | 1 | Reference uses the stack segment |
| pf_req | input | 1 | Translation reported a page fault |
| num_exc | input | 1 | Unmasked numeric exception from the arithmetic |
| fault_vld | output | 1 | Result strobe |
| fault_code | output | 3 | 0 none, 1 UD, 2 NM, 3 GP, 4 SS, 5 PF, 6 XM |

## Verification
Every result appears one clock after the request that carries it. The classification path is purely combinational and feeds a single output register. The bench drives a new snapshot at each falling edge with the request held high. It compares outputs just after the following rising edge, so each compare sees exactly the snapshot applied half a cycle earlier. The sweep covers every mode code, every combination of the single-bit conditions, and four addresses. The addresses are chosen to sit on both sides of the 16-byte alignment and of the 0xFFFF limit. After the sweep, the bench drops the request and checks that the strobe and code return to zero on the next edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   localparam int unsigned CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      FLT_NONE = 3'd0,
      FLT_UD   = 3'd1,
      FLT_NM   = 3'd2,
      FLT_GP   = 3'd3,
      FLT_SS   = 3'd4,
      FLT_PF   = 3'd5,
      FLT_XM   = 3'd6
   } fault_e;

   typedef enum logic [2:0] {
      MD_REAL   = 3'd0,
      MD_V86    = 3'd1,
      MD_PROT   = 3'd2,
      MD_COMPAT = 3'd3,
      MD_LONG   = 3'd4
   } mode_e;

   // Priority slots, index 0 is the highest
   localparam int unsigned SLOT_GATE_UD = 0;
   localparam int unsigned SLOT_NM      = 1;
   localparam int unsigned SLOT_SS      = 2;
   localparam int unsigned SLOT_SEG_GP  = 3;
   localparam int unsigned SLOT_ALN_GP  = 4;
   localparam int unsigned SLOT_PF      = 5;
   localparam int unsigned SLOT_NUM_UD  = 6;
   localparam int unsigned SLOT_NUM_XM  = 7;
   localparam int unsigned NUM_SLOTS    = 8;

   function automatic logic is_flat_mode(input logic [2:0] m);
      return (m == MD_REAL) || (m == MD_V86);
   endfunction

endpackage

// File: rtl/sfc_gate_check.sv
module sfc_gate_check (
   input  logic ctl_emul,
   input  logic ctl_tswitch,
   input  logic ctl_vecstate_os,
   input  logic feat_ok,
   input  logic lock_pfx,
   output logic gate_ud,
   output logic gate_nm
);

   logic [3:0] ud_terms;

   always_comb begin
      ud_terms[0] = ctl_emul;
      ud_terms[1] = ~ctl_vecstate_os;
      ud_terms[2] = ~feat_ok;
      ud_terms[3] = lock_pfx;
   end

   assign gate_ud = |ud_terms;
   assign gate_nm = ctl_tswitch;

endmodule

// File: rtl/sfc_mem_check.sv
module sfc_mem_check #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned ALIGN_BYTES = 16,
   parameter int unsigned OPND_BYTES  = 16,
   parameter int unsigned FLAT_LIMIT  = 32'h0000_FFFF
) (
   input  logic [2:0]        cpu_mode,
   input  logic              mem_op,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              addr_ok,
   input  logic              stack_seg,
   input  logic              pf_req,
   output logic              seg_ss,
   output logic              seg_gp,
   output logic              aln_gp,
   output logic              pf_hit
);
   import sfc_pkg::*;

   localparam int unsigned ALIGN_LSB = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;
   localparam int unsigned SUM_W     = ADDR_W + 1;

   logic             flat;
   logic             bad_legal;
   logic             flat_over;
   logic [SUM_W-1:0] last_byte;

   assign flat      = is_flat_mode(cpu_mode);
   assign last_byte = {1'b0, eff_addr} + SUM_W'(OPND_BYTES - 1);
   assign flat_over = (last_byte > SUM_W'(FLAT_LIMIT));
   assign bad_legal = ~addr_ok & ~flat;

   assign seg_ss = mem_op & bad_legal & stack_seg;
   assign seg_gp = mem_op & ((bad_legal & ~stack_seg) | (flat & flat_over));

   generate
      if (ALIGN_BYTES > 1) begin : g_align
         assign aln_gp = mem_op & (|eff_addr[ALIGN_LSB-1:0]);
      end else begin : g_noalign
         assign aln_gp = 1'b0;
      end
   endgenerate

   assign pf_hit = mem_op & pf_req & (cpu_mode != MD_REAL);

endmodule

// File: rtl/sfc_prio_enc.sv
module sfc_prio_enc #(
   parameter int unsigned N      = 8,
   parameter int unsigned CW     = 3,
   parameter logic [N*CW-1:0] CODE_TABLE = '0
) (
   input  logic [N-1:0]  hit,
   output logic [CW-1:0] code
);

   logic [CW-1:0] stage [N+1];

   assign stage[N] = '0;

   generate
      for (genvar i = N - 1; i >= 0; i--) begin : g_stage
         assign stage[i] = hit[i] ? CODE_TABLE[i*CW +: CW] : stage[i+1];
      end
   endgenerate

   assign code = stage[0];

endmodule

// File: rtl/simd_fault_classifier.sv
module simd_fault_classifier #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned ALIGN_BYTES = 16,
   parameter int unsigned OPND_BYTES  = 16,
   parameter int unsigned FLAT_LIMIT  = 32'h0000_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_req,
   input  logic              ctl_emul,
   input  logic              ctl_tswitch,
   input  logic              ctl_vecstate_os,
   input  logic              ctl_simdx_os,
   input  logic              feat_ok,
   input  logic              lock_pfx,
   input  logic [2:0]        cpu_mode,
   input  logic              mem_op,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              addr_ok,
   input  logic              stack_seg,
   input  logic              pf_req,
   input  logic              num_exc,
   output logic              fault_vld,
   output logic [2:0]        fault_code
);
   import sfc_pkg::*;

   generate
      if (ALIGN_BYTES == 0 || (ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
         $error("ALIGN_BYTES must be a power of two");
      end
      if (OPND_BYTES == 0) begin : g_bad_opnd
         $error("OPND_BYTES must be nonzero");
      end
      if (ADDR_W < 17) begin : g_bad_addr
         $error("ADDR_W must cover the flat-mode limit");
      end
   endgenerate

   localparam logic [NUM_SLOTS*CODE_W-1:0] SLOT_CODES = {
      FLT_XM, FLT_UD, FLT_PF, FLT_GP, FLT_GP, FLT_SS, FLT_NM, FLT_UD
   };

   logic                 gate_ud, gate_nm;
   logic                 seg_ss, seg_gp, aln_gp, pf_hit;
   logic [NUM_SLOTS-1:0] hit;
   logic [CODE_W-1:0]    code_nx;

   sfc_gate_check u_gate (
      .ctl_emul        (ctl_emul),
      .ctl_tswitch     (ctl_tswitch),
      .ctl_vecstate_os (ctl_vecstate_os),
      .feat_ok         (feat_ok),
      .lock_pfx        (lock_pfx),
      .gate_ud         (gate_ud),
      .gate_nm         (gate_nm)
   );

   sfc_mem_check #(
      .ADDR_W      (ADDR_W),
      .ALIGN_BYTES (ALIGN_BYTES),
      .OPND_BYTES  (OPND_BYTES),
      .FLAT_LIMIT  (FLAT_LIMIT)
   ) u_mem (
      .cpu_mode  (cpu_mode),
      .mem_op    (mem_op),
      .eff_addr  (eff_addr),
      .addr_ok   (addr_ok),
      .stack_seg (stack_seg),
      .pf_req    (pf_req),
      .seg_ss    (seg_ss),
      .seg_gp    (seg_gp),
      .aln_gp    (aln_gp),
      .pf_hit    (pf_hit)
   );

   always_comb begin
      hit               = '0;
      hit[SLOT_GATE_UD] = gate_ud;
      hit[SLOT_NM]      = gate_nm;
      hit[SLOT_SS]      = seg_ss;
      hit[SLOT_SEG_GP]  = seg_gp;
      hit[SLOT_ALN_GP]  = aln_gp;
      hit[SLOT_PF]      = pf_hit;
      hit[SLOT_NUM_UD]  = num_exc & ~ctl_simdx_os;
      hit[SLOT_NUM_XM]  = num_exc & ctl_simdx_os;
   end

   sfc_prio_enc #(
      .N          (NUM_SLOTS),
      .CW         (CODE_W),
      .CODE_TABLE (SLOT_CODES)
   ) u_prio (
      .hit  (hit),
      .code (code_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_vld  <= 1'b0;
         fault_code <= '0;
      end else begin
         fault_vld  <= chk_req;
         fault_code <= chk_req ? code_nx : '0;
      end
   end

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       chk_req,
   input logic       ctl_emul,
   input logic       ctl_tswitch,
   input logic       ctl_vecstate_os,
   input logic       ctl_simdx_os,
   input logic       feat_ok,
   input logic       lock_pfx,
   input logic       stack_seg,
   input logic       fault_vld,
   input logic [2:0] fault_code
);

   logic gate_any;
   assign gate_any = ctl_emul | ~ctl_vecstate_os | ~feat_ok | lock_pfx;

   AST_UD_GATE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req && gate_any |=> fault_code == 3'd1); // R1

   AST_NM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req && !gate_any && ctl_tswitch |=> fault_code == 3'd2); // R2

   AST_SS_NEEDS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld && fault_code == 3'd4 |-> $past(stack_seg)); // R3

   AST_XM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld && fault_code == 3'd6 |-> $past(ctl_simdx_os)); // R7

   AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req |=> fault_vld); // R8

   AST_NO_VLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_req |=> !fault_vld); // R8

   AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_vld |-> fault_code == 3'd0); // R8

   AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_code != 3'd7); // R8

endmodule

bind simd_fault_classifier sfc_checker u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .chk_req         (chk_req),
   .ctl_emul        (ctl_emul),
   .ctl_tswitch     (ctl_tswitch),
   .ctl_vecstate_os (ctl_vecstate_os),
   .ctl_simdx_os    (ctl_simdx_os),
   .feat_ok         (feat_ok),
   .lock_pfx        (lock_pfx),
   .stack_seg       (stack_seg),
   .fault_vld       (fault_vld),
   .fault_code      (fault_code)
);

// File: tb/sim_simd_fault_classifier.sv
`timescale 1ns/1ps
module sim_simd_fault_classifier;

   localparam int ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chk_req = 1'b0;
   logic              ctl_emul = 1'b0, ctl_tswitch = 1'b0, ctl_vecstate_os = 1'b0;
   logic              ctl_simdx_os = 1'b0, feat_ok = 1'b0, lock_pfx = 1'b0;
   logic [2:0]        cpu_mode = '0;
   logic              mem_op = 1'b0;
   logic [ADDR_W-1:0] eff_addr = '0;
   logic              addr_ok = 1'b0, stack_seg = 1'b0, pf_req = 1'b0, num_exc = 1'b0;
   logic              fault_vld;
   logic [2:0]        fault_code;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   simd_fault_classifier #(.ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .chk_req(chk_req),
      .ctl_emul(ctl_emul), .ctl_tswitch(ctl_tswitch),
      .ctl_vecstate_os(ctl_vecstate_os), .ctl_simdx_os(ctl_simdx_os),
      .feat_ok(feat_ok), .lock_pfx(lock_pfx), .cpu_mode(cpu_mode),
      .mem_op(mem_op), .eff_addr(eff_addr), .addr_ok(addr_ok),
      .stack_seg(stack_seg), .pf_req(pf_req), .num_exc(num_exc),
      .fault_vld(fault_vld), .fault_code(fault_code)
   );

   logic [31:0] addr_set [4];
   initial begin
      addr_set[0] = 32'h0000_0040;
      addr_set[1] = 32'h0000_0043;
      addr_set[2] = 32'h0000_FFF0;
      addr_set[3] = 32'h0001_0000;
   end

   task automatic check(input string tag, input logic exp_v, input logic [2:0] exp_c);
      vectors++;
      if (fault_vld !== exp_v || fault_code !== exp_c) begin
         miscompares++;
         $display("FAIL %s: vld=%0b code=%0d expected vld=%0b code=%0d (mode=%0d addr=%h)",
                  tag, fault_vld, fault_code, exp_v, exp_c, cpu_mode, eff_addr);
      end
   endtask

   // Reference model straight from the requirements
   task automatic model(output logic [2:0] c, output string tag);
      logic [32:0] last;
      bit flat;
      last = {1'b0, eff_addr} + 33'd15;
      flat = (cpu_mode == 3'd0) || (cpu_mode == 3'd1);
      if (ctl_emul || !ctl_vecstate_os || !feat_ok || lock_pfx) begin c = 3'd1; tag = "R1"; end
      else if (ctl_tswitch) begin c = 3'd2; tag = "R2"; end
      else if (mem_op && !flat && !addr_ok) begin c = stack_seg ? 3'd4 : 3'd3; tag = "R3"; end
      else if (mem_op && flat && last > 33'h0FFFF) begin c = 3'd3; tag = "R4"; end
      else if (mem_op && eff_addr[3:0] != 4'd0) begin c = 3'd3; tag = "R5"; end
      else if (mem_op && pf_req && cpu_mode != 3'd0) begin c = 3'd5; tag = "R6"; end
      else if (num_exc) begin c = ctl_simdx_os ? 3'd6 : 3'd1; tag = "R7"; end
      else begin c = 3'd0; tag = "R8"; end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R9", 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R9", 1'b0, 3'd0);

      for (int m = 0; m < 8; m++) begin
         for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 2048; b++) begin
               logic [2:0] ec;
               string      et;
               @(negedge clk);
               cpu_mode        = 3'(m);
               eff_addr        = addr_set[a];
               ctl_emul        = b[0];
               ctl_tswitch     = b[1];
               ctl_vecstate_os = b[2];
               ctl_simdx_os    = b[3];
               feat_ok         = b[4];
               lock_pfx        = b[5];
               mem_op          = b[6];
               addr_ok         = b[7];
               stack_seg       = b[8];
               pf_req          = b[9];
               num_exc         = b[10];
               chk_req         = 1'b1;
               model(ec, et);
               @(posedge clk);
               #1;
               check(et, 1'b1, ec);
            end
         end
      end

      @(negedge clk);
      chk_req = 1'b0;
      num_exc = 1'b1;
      @(posedge clk);
      #1;
      check("R8", 1'b0, 3'd0);
      @(posedge clk);
      #1;
      check("R8", 1'b0, 3'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule